// File: doc/BRIEF.md
# Receive Descriptor Status Writeback

This block finishes the handling of each receive buffer in a network receive DMA engine. While a buffer is being filled, the receive path raises plain strobes for FIFO overflow and for a receive error reported by the PHY. The block keeps both as sticky flags. When the buffer is done, the receive path presents a close-out request carrying:

- the descriptor's status address;
- first-buffer and last-buffer markers;
- the FCS check result;
- a dribble-bit (non-octet length) flag;
- a bus parity error flag;
- whether the next descriptor is owned by the controller;
- the byte count.

From these inputs the block builds the 32-bit status word. It gates the error bits so that each is reported only where it is valid. It always writes OWN = 0, which hands the descriptor back to the host. It sends the word out as a single-beat write.

Both the close-out request and the memory write are valid/ready streams. A close-out is accepted when `cls_valid` and `cls_ready` are both high at a clock edge. `cls_ready` is high only when no write is pending, so a request stalls until the previous write has completed. Once `wr_valid` rises, address and data stay unchanged until `wr_ready` is sampled high. After that `wr_valid` drops, so each descriptor is written exactly once.

Status word layout:

| Bits | Content |
|---|---|
| 31 | OWN |
| 30 | ERR |
| 29 | FRAM |
| 28 | OFLO |
| 27 | CRC |
| 26 | BUFF |
| 25 | STP |
| 24 | ENP |
| 23 | BPE |
| 22:16 | zero |
| 15:12 | 1111 |
| 11:0 | byte count |

Top module: `rx_desc_closeout`

## Requirements
- R1: Every written status word has bit 31 (OWN) equal to 0. `wr_addr` equals the `cls_addr` of the accepted request.
- R2: Bit 30 (ERR) equals the OR of bits 29, 28, 27, 26 and 23.
- R3: Bit 29 (FRAM) is 1 only when all of these hold: `cls_last`=1, no overflow is reported in this word, `cls_fcs_bad`=1 and `cls_dribble`=1.
- R4: Bit 27 (CRC) is 1 only when `cls_last`=1 and no overflow is reported in this word, and at least one of these holds:
  - `cls_fcs_bad`=1;
  - `ev_phy_err` was seen since the last close-out that had `cls_last`=1, including the acceptance cycle.
- R5: Bit 28 (OFLO) is 1 exactly when `ev_ovf` was high in any cycle since the previous accepted close-out, up to and including the acceptance cycle.
- R6: Bit 26 (BUFF) is 1 exactly when `cls_last`=0 and `cls_next_owned`=0.
- R7: Bit 25 copies `cls_first` (STP). Bit 24 copies `cls_last` (ENP). Bit 23 copies `cls_parity_err` (BPE).
- R8: Bits 15:12 are 1111. Bits 22:16 are 0. Bits 11:0 carry `cls_bcnt`.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold. During that time `cls_ready` is low.
- R10: In the cycle after a write handshake, `wr_valid` is low, so each accepted close-out produces exactly one write.
- R11: After reset, `wr_valid` is 0, `cls_ready` is 1, and no overflow or PHY error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_ovf | input | 1 | Receive FIFO overflow strobe |
| ev_phy_err | input | 1 | PHY receive-error strobe |
| cls_valid | input | 1 | Close-out request valid |
| cls_ready | output | 1 | Close-out request ready (no write pending) |
| cls_addr | input | 32 | Status word address of the descriptor |
| cls_first | input | 1 | Buffer is the first of its frame |
| cls_last | input | 1 | Buffer is the last of its frame |
| cls_fcs_bad | input | 1 | Frame check sequence mismatch |
| cls_dribble | input | 1 | Frame length not a whole number of octets |
| cls_next_owned | input | 1 | Controller owns the next descriptor |
| cls_parity_err | input | 1 | Bus parity error during the buffer |
| cls_bcnt | input | 12 | Byte count for the status word |
| wr_valid | output | 1 | Status write valid |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | 32 | Status write address |
| wr_data | output | 32 | Status word |

## Verification
The bench sweeps all 256 combinations of the first and last markers, FCS result, dribble flag, next-descriptor ownership, parity error, overflow and PHY error. Each combination is run with the overflow strobe arriving either one cycle before acceptance or in the acceptance cycle itself, which separates sticky capture from same-cycle capture.

The sweep also distinguishes several error cases from one another:

- FCS errors with and without dribble;
- PHY-only errors;
- overflow masking FRAM and CRC;
- a PHY error carried across non-final buffers into the final one.

Each write is held for zero to two cycles of back-pressure. This shows that the word stays stable, that no new request is taken while the write is pending, and that `wr_valid` falls right after the handshake.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int ADDR_W = 32;
  localparam int BCNT_W = 12;
  localparam int RSV_W  = 32 - 9 - 4 - BCNT_W;

  typedef struct packed {
    logic              own;
    logic              err;
    logic              fram;
    logic              oflo;
    logic              crc;
    logic              buff;
    logic              stp;
    logic              enp;
    logic              bpe;
    logic [RSV_W-1:0]  rsvd;
    logic [3:0]        ones;
    logic [BCNT_W-1:0] bcnt;
  } rxd_status_t;
endpackage

// File: rtl/rxd_err_accum.sv
module rxd_err_accum (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_ovf,
  input  logic ev_phy_err,
  input  logic take,
  input  logic take_last,
  output logic ovf_seen,
  output logic phy_seen
);
  logic ovf_q, phy_q;

  assign ovf_seen = ovf_q | ev_ovf;
  assign phy_seen = phy_q | ev_phy_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      phy_q <= 1'b0;
    end else if (take) begin
      ovf_q <= 1'b0;                       // overflow reported per buffer
      phy_q <= take_last ? 1'b0 : phy_seen; // PHY error spans the frame
    end else begin
      ovf_q <= ovf_seen;
      phy_q <= phy_seen;
    end
  end
endmodule

// File: rtl/rxd_status_build.sv
module rxd_status_build
  import rxd_pkg::*;
(
  input  logic              first,
  input  logic              last,
  input  logic              fcs_bad,
  input  logic              dribble,
  input  logic              next_owned,
  input  logic              parity_err,
  input  logic              ovf_seen,
  input  logic              phy_seen,
  input  logic [BCNT_W-1:0] bcnt,
  output rxd_status_t       status
);
  logic gate_ok;

  always_comb begin
    // FRAM and CRC are only meaningful on the final buffer without loss
    gate_ok       = last & ~ovf_seen;
    status        = '0;
    status.own    = 1'b0;
    status.oflo   = ovf_seen;
    status.fram   = gate_ok & fcs_bad & dribble;
    status.crc    = gate_ok & (fcs_bad | phy_seen);
    status.buff   = ~last & ~next_owned;
    status.stp    = first;
    status.enp    = last;
    status.bpe    = parity_err;
    status.err    = status.fram | status.oflo | status.crc | status.buff | status.bpe;
    status.rsvd   = '0;
    status.ones   = 4'hF;
    status.bcnt   = bcnt;
  end
endmodule

// File: rtl/rxd_wb_port.sv
module rxd_wb_port #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic          busy,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  assign busy = wr_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= load_addr;
      wr_data  <= load_data;
    end else if (wr_valid && wr_ready) begin
      wr_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rx_desc_closeout.sv
module rx_desc_closeout
  import rxd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ovf,
  input  logic              ev_phy_err,
  input  logic              cls_valid,
  output logic              cls_ready,
  input  logic [ADDR_W-1:0] cls_addr,
  input  logic              cls_first,
  input  logic              cls_last,
  input  logic              cls_fcs_bad,
  input  logic              cls_dribble,
  input  logic              cls_next_owned,
  input  logic              cls_parity_err,
  input  logic [BCNT_W-1:0] cls_bcnt,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);
  logic        take, busy, ovf_seen, phy_seen;
  rxd_status_t status;

  assign cls_ready = ~busy;
  assign take      = cls_valid & cls_ready;

  rxd_err_accum u_accum (
    .clk(clk), .rst_n(rst_n),
    .ev_ovf(ev_ovf), .ev_phy_err(ev_phy_err),
    .take(take), .take_last(cls_last),
    .ovf_seen(ovf_seen), .phy_seen(phy_seen)
  );

  rxd_status_build u_build (
    .first(cls_first), .last(cls_last), .fcs_bad(cls_fcs_bad),
    .dribble(cls_dribble), .next_owned(cls_next_owned),
    .parity_err(cls_parity_err), .ovf_seen(ovf_seen),
    .phy_seen(phy_seen), .bcnt(cls_bcnt), .status(status)
  );

  rxd_wb_port #(.AW(ADDR_W), .DW(32)) u_wb (
    .clk(clk), .rst_n(rst_n),
    .load(take), .load_addr(cls_addr), .load_data(status),
    .busy(busy), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );
endmodule

// File: rtl/rx_desc_closeout_chk.sv
module rx_desc_closeout_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cls_valid,
  input logic        cls_ready,
  input logic        cls_last,
  input logic        cls_next_owned,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic [31:0] wr_addr,
  input logic [31:0] wr_data
);
  a_r1_own_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !wr_data[31]);
  a_r2_err_summary: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[30] == (|{wr_data[29:26], wr_data[23]})));
  a_r3_fram_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data[29]) |-> (wr_data[24] && !wr_data[28]));
  a_r4_crc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_data[27]) |-> (wr_data[24] && !wr_data[28]));
  a_r6_buff_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls_ready) |=> (wr_data[26] == (!$past(cls_last) && !$past(cls_next_owned))));
  a_r8_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_data[15:12] == 4'hF && wr_data[22:16] == 7'd0));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));
  a_r9_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !cls_ready);
  a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !wr_valid);
endmodule

bind rx_desc_closeout rx_desc_closeout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cls_valid(cls_valid), .cls_ready(cls_ready),
  .cls_last(cls_last), .cls_next_owned(cls_next_owned),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
);

// File: tb/rx_desc_closeout_tb.sv
module rx_desc_closeout_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_ovf = 0, ev_phy_err = 0, cls_valid = 0;
  logic        cls_ready;
  logic [31:0] cls_addr = '0;
  logic        cls_first = 0, cls_last = 0, cls_fcs_bad = 0, cls_dribble = 0;
  logic        cls_next_owned = 0, cls_parity_err = 0;
  logic [11:0] cls_bcnt = '0;
  logic        wr_valid, wr_ready = 0;
  logic [31:0] wr_addr, wr_data;

  int n_vec = 0, n_bad = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_closeout u_dut (
    .clk(clk), .rst_n(rst_n), .ev_ovf(ev_ovf), .ev_phy_err(ev_phy_err),
    .cls_valid(cls_valid), .cls_ready(cls_ready), .cls_addr(cls_addr),
    .cls_first(cls_first), .cls_last(cls_last), .cls_fcs_bad(cls_fcs_bad),
    .cls_dribble(cls_dribble), .cls_next_owned(cls_next_owned),
    .cls_parity_err(cls_parity_err), .cls_bcnt(cls_bcnt),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_word(input logic f, l, fcs, drb, nxt, par, ovf, phy,
                                              input logic [11:0] bc);
    logic fram, crc, buff, err;
    fram = l & ~ovf & fcs & drb;
    crc  = l & ~ovf & (fcs | phy);
    buff = ~l & ~nxt;
    err  = fram | ovf | crc | buff | par;
    return {1'b0, err, fram, ovf, crc, buff, f, l, par, 7'd0, 4'hF, bc};
  endfunction

  initial begin
    logic phy_pend = 0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 wr_valid", {31'd0, wr_valid}, 32'd0);
    check("R11 cls_ready", {31'd0, cls_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 idle after reset", {30'd0, wr_valid, cls_ready}, 32'd1);
    for (int i = 0; i < 512; i++) begin
      logic [31:0] exp_w, exp_a;
      logic        ovf_b, phy_b, same;
      ovf_b = i[6]; phy_b = i[7]; same = i[8];
      // strobe cycle
      ev_ovf = ovf_b & ~same;
      ev_phy_err = phy_b;
      @(negedge clk);
      ev_phy_err = 0;
      ev_ovf = ovf_b & same;
      cls_valid = 1;
      cls_first = i[0]; cls_last = i[1]; cls_fcs_bad = i[2]; cls_dribble = i[3];
      cls_next_owned = i[4]; cls_parity_err = i[5];
      cls_bcnt = 12'((i * 37 + 5) & 12'hFFF);
      cls_addr = 32'h1000_0000 + 32'(i) * 16;
      exp_w = expect_word(i[0], i[1], i[2], i[3], i[4], i[5], ovf_b, phy_pend | phy_b, cls_bcnt);
      exp_a = cls_addr;
      check("R9 cls_ready before request", {31'd0, cls_ready}, 32'd1);
      @(negedge clk);
      phy_pend = i[1] ? 1'b0 : (phy_pend | phy_b);
      cls_valid = 0; ev_ovf = 0;
      // R1 R2 R3 R4 R5 R6 R7 R8: full status word
      check("R1-word/R2/R3/R4/R5/R6/R7/R8 status", wr_data, exp_w);
      check("R1 address", wr_addr, exp_a);
      check("R9 pending", {30'd0, wr_valid, cls_ready}, 32'd2);
      for (int k = 0; k < i % 3; k++) begin
        cls_valid = 1;  // must be refused while pending (R9)
        @(negedge clk);
        check("R9 hold data", wr_data, exp_w);
        check("R9 hold valid/ready", {30'd0, wr_valid, cls_ready}, 32'd2);
      end
      cls_valid = 0;
      wr_ready = 1;
      @(negedge clk);
      wr_ready = 0;
      check("R10 single write", {31'd0, wr_valid}, 32'd0);
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule